// File: doc/BRIEF.md
# SPI Flash Status-Register Write Sequencer

This block lives on the host side of a serial NOR flash link. On a start pulse it writes one new byte into the flash's status register. It first sends a write-enable opcode in its own chip-select frame. It then sends a frame that carries the write-status opcode and the data byte. Two per-chip flags choose the enable opcode: the plain write-enable (06h) or the enable-write-status opcode (50h). If the plain style fails and the other style is allowed, the whole sequence runs again with the other opcode.

After the write the flash performs a slow internal erase and program. The sequencer waits a long initial delay and then reads the status register. It repeats the read at a coarse step while the busy bit stays set, and gives up after a bounded number of step waits. A millisecond tick is derived from a clock-count parameter, so a bench can shorten both waits without changing the millisecond counts.

The block drives chip select itself. It reaches the serial shifter through a byte-level request/acknowledge handshake: it holds a request with a byte, and the shifter answers with an acknowledge pulse, the byte it received and an error flag.

Top module: `sr_write_seq`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_req`, `busy` and `done` are 0, and `result` is 00.
- R2: When `cfg_wren`=1, the first frame holds exactly one byte, 06h. The next frame holds exactly two bytes: 01h, then the start value.
- R3: When both `cfg_wren` and `cfg_ewsr` are 0, the enable frame carries 50h.
- R4: When only `cfg_ewsr`=1, the enable frame carries 50h and no 06h frame is sent.
- R5: When both flags are 1 and the 06h attempt fails, the whole sequence is repeated starting with a 50h enable frame. When only `cfg_wren`=1, a failure is not retried.
- R6: An acknowledge with `spi_err`=1 ends the attempt at once with result 01 (command error). No status-read frame is issued after a failed enable or write frame.
- R7: The first status-read frame begins INIT_MS milliseconds after chip select rises at the end of the write frame, within a few clocks. A millisecond is CLKS_PER_MS clocks.
- R8: Each status-read frame is two bytes: 05h, then a fill byte. Bit 0 of the byte received during the fill byte is the busy flag. While it is 1, another read follows STEP_MS milliseconds later. When it is 0 the run ends with result 00. Bit 1 (write-enable latch) does not affect the outcome.
- R9: When the busy flag is still 1 after POLL_LIMIT step waits, which is POLL_LIMIT+1 reads, the run ends with result 10 (timeout).
- R10: `done` is high for exactly one cycle per run. `result` changes only with `done` and holds until the next run ends. `busy` is 1 from the cycle after start until `done`.
- R11: A start pulse while `busy`=1 has no effect: the running sequence keeps its value and opcode, and only one `done` follows.
- R12: Between two frames `spi_cs_n` stays high for at least CS_GAP clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; sampled only while idle |
| wr_value | input | 8 | Status value to write, captured on start |
| cfg_wren | input | 1 | Chip accepts the plain write-enable opcode |
| cfg_ewsr | input | 1 | Chip accepts the enable-write-status opcode |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_req | output | 1 | Byte transfer request to the shifter |
| spi_byte | output | 8 | Byte to shift out, stable while requested |
| spi_ack | input | 1 | One-cycle pulse: byte transfer finished |
| spi_rx | input | 8 | Byte shifted in, valid with `spi_ack` |
| spi_err | input | 1 | Transfer failed, valid with `spi_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 ok, 01 command error, 10 timeout; held until the next completion |

## Verification
The bench targets the retry rule. A design that skips the fallback returns a command error where two flags are set. A design that retries with only the plain flag set issues a stray 50h frame. For errors it checks that nothing is polled after a failed write; a design that polls anyway shows extra 05h frames. The poll bound is checked by counting exactly POLL_LIMIT+1 reads on a flash that stays busy, so an off-by-one shows up as one read too many or too few. The bench also measures the initial and step delays and the chip-select gap, and it checks that a start during a run neither restarts the run nor changes its value.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_CMD_ERR = 2'd1,
      RES_TIMEOUT = 2'd2
   } sr_res_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_EN_OP,
      ST_GAP,
      ST_WR_OP,
      ST_WR_DAT,
      ST_WAIT_INIT,
      ST_RD_OP,
      ST_RD_DAT,
      ST_WAIT_STEP
   } sr_state_e;

   // chip select is low exactly while a byte of a frame is being moved
   function automatic logic in_frame(input sr_state_e s);
      return (s == ST_EN_OP) || (s == ST_WR_OP) || (s == ST_WR_DAT) ||
             (s == ST_RD_OP) || (s == ST_RD_DAT);
   endfunction

endpackage

// File: rtl/sr_ms_tick.sv
module sr_ms_tick #(
   parameter int CLKS_PER_MS = 125000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic tick
);

   initial begin
      EL_TICK_CPM : assert (CLKS_PER_MS >= 1) else $error("CLKS_PER_MS must be at least 1");
   end

   generate
      if (CLKS_PER_MS == 1) begin : g_every
         assign tick = !clear;
      end else begin : g_count
         localparam int CNT_W = $clog2(CLKS_PER_MS);
         localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CLKS_PER_MS - 1);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt <= '0;
            else if (clear)          cnt <= '0;
            else if (cnt == CNT_TOP) cnt <= '0;
            else                     cnt <= cnt + 1'b1;
         end

         assign tick = !clear && (cnt == CNT_TOP);

         AST_TICK_AFTER_CLEAR : assert property (@(posedge clk) disable iff (!rst_n)
            clear |=> !tick) else $error("tick right after clear"); // R7
      end
   endgenerate

endmodule

// File: rtl/sr_delay_timer.sv
module sr_delay_timer #(
   parameter int CLKS_PER_MS = 125000,
   parameter int MS_W        = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [MS_W-1:0] ms_in,
   output logic            expired
);

   logic [MS_W-1:0] ms_left;
   logic            tick;
   logic            tick_clr;

   assign tick_clr = load || (ms_left == '0);

   sr_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (tick_clr),
      .tick  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms_left <= '0;
         expired <= 1'b0;
      end else begin
         expired <= 1'b0;
         if (load) begin
            ms_left <= ms_in;
         end else if (tick && (ms_left != '0)) begin
            ms_left <= ms_left - 1'b1;
            expired <= (ms_left == MS_W'(1));
         end
      end
   end

   AST_NO_EARLY_EXPIRY : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !expired) else $error("expiry right after load"); // R7
   AST_EXPIRY_PULSE : assert property (@(posedge clk) disable iff (!rst_n)
      expired |=> !expired) else $error("expiry longer than one cycle"); // R8

endmodule

// File: rtl/sr_poll_budget.sv
module sr_poll_budget #(
   parameter int LIMIT = 490
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bump,
   output logic spent
);

   localparam int CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LIMIT);

   logic [CNT_W-1:0] cnt;

   initial begin
      EL_BUDGET_LIMIT : assert (LIMIT >= 1) else $error("LIMIT must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (clear)                 cnt <= '0;
      else if (bump && cnt < CNT_TOP) cnt <= cnt + 1'b1;
   end

   assign spent = (cnt == CNT_TOP);

   AST_NO_OVERFLOW : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_TOP) else $error("poll budget overflow"); // R9
   AST_BUMP_BELOW_LIMIT : assert property (@(posedge clk) disable iff (!rst_n)
      bump |-> !spent) else $error("step wait granted past the limit"); // R9

endmodule

// File: rtl/sr_write_seq.sv
module sr_write_seq
   import sr_seq_pkg::*;
#(
   parameter int         CLKS_PER_MS = 125000,
   parameter int         INIT_MS     = 100,
   parameter int         STEP_MS     = 10,
   parameter int         POLL_LIMIT  = 490,
   parameter int         CS_GAP      = 2,
   parameter logic [7:0] OPC_WREN    = 8'h06,
   parameter logic [7:0] OPC_EWSR    = 8'h50,
   parameter logic [7:0] OPC_WRSR    = 8'h01,
   parameter logic [7:0] OPC_RDSR    = 8'h05,
   parameter logic [7:0] FILL_BYTE   = 8'h00,
   parameter logic [7:0] BUSY_MASK   = 8'h01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] wr_value,
   input  logic       cfg_wren,
   input  logic       cfg_ewsr,
   output logic       spi_cs_n,
   output logic       spi_req,
   output logic [7:0] spi_byte,
   input  logic       spi_ack,
   input  logic [7:0] spi_rx,
   input  logic       spi_err,
   output logic       busy,
   output logic       done,
   output logic [1:0] result
);

   localparam int MS_MAX = (INIT_MS > STEP_MS) ? INIT_MS : STEP_MS;
   localparam int MS_W   = $clog2(MS_MAX + 1);
   localparam int GAP_W  = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
   localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(CS_GAP - 1);
   localparam logic [MS_W-1:0]  INIT_LD  = MS_W'(INIT_MS);
   localparam logic [MS_W-1:0]  STEP_LD  = MS_W'(STEP_MS);

   initial begin
      EL_GAP_MIN  : assert (CS_GAP >= 1) else $error("CS_GAP must be at least 1");
      EL_INIT_MIN : assert (INIT_MS >= 1 && INIT_MS * CLKS_PER_MS > CS_GAP)
                       else $error("initial wait shorter than the chip-select gap");
      EL_STEP_MIN : assert (STEP_MS >= 1 && STEP_MS * CLKS_PER_MS > CS_GAP)
                       else $error("step wait shorter than the chip-select gap");
      EL_MASK_SET : assert (BUSY_MASK != 8'h00) else $error("BUSY_MASK is empty");
   end

   sr_state_e        st, st_n, ret_st, ret_n;
   logic [GAP_W-1:0] gap_cnt, gap_n;
   logic [7:0]       en_opc, opc_n;
   logic             retry_ok, retry_n;
   logic [7:0]       val_q, val_n;
   logic             done_q, done_n;
   sr_res_e          res_q, res_n;

   logic             t_load;
   logic [MS_W-1:0]  t_ms;
   logic             t_expired;
   logic             b_clr, b_bump, b_spent;
   logic             fail;
   sr_res_e          fail_code;
   logic             ack_ok, ack_bad;

   sr_delay_timer #(.CLKS_PER_MS(CLKS_PER_MS), .MS_W(MS_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (t_load),
      .ms_in   (t_ms),
      .expired (t_expired)
   );

   sr_poll_budget #(.LIMIT(POLL_LIMIT)) u_budget (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (b_clr),
      .bump  (b_bump),
      .spent (b_spent)
   );

   assign ack_ok  = spi_ack && !spi_err;
   assign ack_bad = spi_ack &&  spi_err;

   always_comb begin
      st_n      = st;
      ret_n     = ret_st;
      gap_n     = gap_cnt;
      opc_n     = en_opc;
      retry_n   = retry_ok;
      val_n     = val_q;
      done_n    = 1'b0;
      res_n     = res_q;
      t_load    = 1'b0;
      t_ms      = '0;
      b_clr     = 1'b0;
      b_bump    = 1'b0;
      fail      = 1'b0;
      fail_code = RES_OK;

      unique case (st)
         ST_IDLE: begin
            if (start) begin
               val_n = wr_value;
               if (cfg_wren) begin
                  opc_n   = OPC_WREN;
                  retry_n = cfg_ewsr;
               end else begin
                  // no flag at all falls back to the status-enable opcode
                  opc_n   = OPC_EWSR;
                  retry_n = 1'b0;
               end
               st_n = ST_EN_OP;
            end
         end
         ST_EN_OP: begin
            if (ack_bad) begin
               fail = 1'b1; fail_code = RES_CMD_ERR;
            end else if (ack_ok) begin
               st_n  = ST_GAP;
               gap_n = GAP_LOAD;
               ret_n = ST_WR_OP;
            end
         end
         ST_GAP: begin
            if (gap_cnt == '0) st_n = ret_st;
            else               gap_n = gap_cnt - 1'b1;
         end
         ST_WR_OP: begin
            if (ack_bad)     begin fail = 1'b1; fail_code = RES_CMD_ERR; end
            else if (ack_ok) st_n = ST_WR_DAT;
         end
         ST_WR_DAT: begin
            if (ack_bad) begin
               fail = 1'b1; fail_code = RES_CMD_ERR;
            end else if (ack_ok) begin
               t_load = 1'b1;
               t_ms   = INIT_LD;
               b_clr  = 1'b1;
               st_n   = ST_WAIT_INIT;
            end
         end
         ST_WAIT_INIT, ST_WAIT_STEP: begin
            if (t_expired) st_n = ST_RD_OP;
         end
         ST_RD_OP: begin
            if (ack_bad)     begin fail = 1'b1; fail_code = RES_CMD_ERR; end
            else if (ack_ok) st_n = ST_RD_DAT;
         end
         ST_RD_DAT: begin
            if (ack_bad) begin
               fail = 1'b1; fail_code = RES_CMD_ERR;
            end else if (ack_ok) begin
               if ((spi_rx & BUSY_MASK) != 8'h00) begin
                  if (b_spent) begin
                     fail = 1'b1; fail_code = RES_TIMEOUT;
                  end else begin
                     b_bump = 1'b1;
                     t_load = 1'b1;
                     t_ms   = STEP_LD;
                     st_n   = ST_WAIT_STEP;
                  end
               end else begin
                  st_n   = ST_IDLE;
                  done_n = 1'b1;
                  res_n  = RES_OK;
               end
            end
         end
         default: st_n = ST_IDLE;
      endcase

      if (fail) begin
         if (retry_ok) begin
            retry_n = 1'b0;
            opc_n   = OPC_EWSR;
            st_n    = ST_GAP;
            gap_n   = GAP_LOAD;
            ret_n   = ST_EN_OP;
         end else begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
            res_n  = fail_code;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         ret_st   <= ST_IDLE;
         gap_cnt  <= '0;
         en_opc   <= OPC_EWSR;
         retry_ok <= 1'b0;
         val_q    <= 8'h00;
         done_q   <= 1'b0;
         res_q    <= RES_OK;
      end else begin
         st       <= st_n;
         ret_st   <= ret_n;
         gap_cnt  <= gap_n;
         en_opc   <= opc_n;
         retry_ok <= retry_n;
         val_q    <= val_n;
         done_q   <= done_n;
         res_q    <= res_n;
      end
   end

   always_comb begin
      unique case (st)
         ST_EN_OP:  spi_byte = en_opc;
         ST_WR_OP:  spi_byte = OPC_WRSR;
         ST_WR_DAT: spi_byte = val_q;
         ST_RD_OP:  spi_byte = OPC_RDSR;
         default:   spi_byte = FILL_BYTE;
      endcase
   end

   assign spi_req  = in_frame(st);
   assign spi_cs_n = !in_frame(st);
   assign busy     = (st != ST_IDLE);
   assign done     = done_q;
   assign result   = res_q;

   AST_DONE_PULSE : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done wider than one cycle"); // R10
   AST_RESULT_HELD : assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result)) else $error("result moved without done"); // R10
   AST_REQ_HOLD : assert property (@(posedge clk) disable iff (!rst_n)
      (spi_req && !spi_ack) |=> (spi_req && $stable(spi_byte))) else $error("request dropped"); // R2
   AST_CS_GAP : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |=> spi_cs_n) else $error("chip-select gap too short"); // R12
   AST_DONE_ENDS_BUSY : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy) else $error("done while still busy"); // R10
   AST_NO_POLL_AFTER_ERR : assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == RES_CMD_ERR) |-> spi_cs_n) else $error("frame open at error"); // R6

endmodule

// File: tb/sr_write_seq_test.sv
module sr_write_seq_test;

   localparam int CPM  = 4;
   localparam int GAP  = 2;
   localparam int LAT  = 2;
   localparam int INIT = 100;
   localparam int STEP = 10;
   localparam int LIM  = 490;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] wr_value = 8'h00;
   logic       cfg_wren = 1'b0;
   logic       cfg_ewsr = 1'b0;
   logic       spi_cs_n, spi_req;
   logic [7:0] spi_byte;
   logic       spi_ack = 1'b0;
   logic [7:0] spi_rx = 8'h00;
   logic       spi_err = 1'b0;
   logic       busy, done;
   logic [1:0] result;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;   // 125 MHz

   sr_write_seq #(
      .CLKS_PER_MS(CPM), .INIT_MS(INIT), .STEP_MS(STEP),
      .POLL_LIMIT(LIM), .CS_GAP(GAP)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .wr_value(wr_value),
      .cfg_wren(cfg_wren), .cfg_ewsr(cfg_ewsr),
      .spi_cs_n(spi_cs_n), .spi_req(spi_req), .spi_byte(spi_byte),
      .spi_ack(spi_ack), .spi_rx(spi_rx), .spi_err(spi_err),
      .busy(busy), .done(done), .result(result)
   );

   // ---------------- flash + shifter model ----------------
   int         cyc = 0;
   bit         cs_prev = 1'b1;
   int         t_rise = -100000;
   int         nfr = 0;
   int         cur_idx = 0;
   logic [7:0] cur_op = 8'h00;
   logic [7:0] last_op = 8'h00;
   logic [7:0] fr_op [0:7];
   logic [7:0] fr_b1 [0:7];
   int         fr_len [0:7];
   int         reads = 0;
   int         busy_left = 0;
   logic [7:0] idle_st = 8'h00;
   int         err_frm = 0;
   int         init_delta = -1;
   int         step_min = 1000000;
   int         step_max = -1;
   int         min_gap = 1000000;
   bit         pending = 1'b0;
   int         lat_cnt = 0;

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cs_prev && !spi_cs_n) begin
         if (cyc - t_rise < min_gap) min_gap = cyc - t_rise;
         if (last_op == 8'h01) init_delta = cyc - t_rise;
         if (last_op == 8'h05) begin
            if (cyc - t_rise < step_min) step_min = cyc - t_rise;
            if (cyc - t_rise > step_max) step_max = cyc - t_rise;
         end
         nfr = nfr + 1;
         cur_idx = 0;
         if (nfr <= 8) fr_len[nfr-1] = 0;
      end
      if (!cs_prev && spi_cs_n) begin
         t_rise = cyc;
         last_op = cur_op;
      end
      cs_prev = spi_cs_n;

      spi_ack <= 1'b0;
      spi_err <= 1'b0;
      if (spi_req && !spi_ack && !pending) begin
         pending = 1'b1;
         lat_cnt = LAT;
      end else if (pending) begin
         if (lat_cnt == 0) begin
            pending = 1'b0;
            spi_ack <= 1'b1;
            spi_err <= (err_frm == nfr) && (cur_idx == 0);
            if (cur_idx == 0) begin
               cur_op = spi_byte;
               if (spi_byte == 8'h05) reads = reads + 1;
               if (nfr <= 8) fr_op[nfr-1] = spi_byte;
               spi_rx <= 8'h00;
            end else begin
               if (nfr <= 8 && cur_idx == 1) fr_b1[nfr-1] = spi_byte;
               if (cur_op == 8'h05 && busy_left > 0) begin
                  spi_rx <= 8'h03;
                  busy_left = busy_left - 1;
               end else begin
                  spi_rx <= idle_st;
               end
            end
            if (nfr <= 8) fr_len[nfr-1] = fr_len[nfr-1] + 1;
            cur_idx = cur_idx + 1;
         end else begin
            lat_cnt = lat_cnt - 1;
         end
      end
   end

   // ---------------- bench helpers ----------------
   int done_cnt = 0;
   int run_res  = 0;
   bit busy_seen = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run(input logic [7:0] v, input bit w, input bit e, input int busy_n,
                      input logic [7:0] ist, input int efrm, input bit poke);
      nfr = 0; reads = 0; init_delta = -1; step_min = 1000000; step_max = -1;
      min_gap = 1000000; last_op = 8'h00; cur_op = 8'h00;
      busy_left = busy_n; idle_st = ist; err_frm = efrm;
      done_cnt = 0; busy_seen = 1'b0;
      for (int i = 0; i < 8; i++) begin fr_op[i] = 8'h00; fr_b1[i] = 8'h00; fr_len[i] = 0; end
      @(negedge clk);
      wr_value = v; cfg_wren = w; cfg_ewsr = e; start = 1'b1;
      @(negedge clk);
      start = 1'b0; wr_value = 8'h00; cfg_wren = 1'b0; cfg_ewsr = 1'b0;
      busy_seen = busy;
      for (int n = 0; n < 60000; n++) begin
         if (poke && n == 50) begin
            start = 1'b1; wr_value = 8'hFF; cfg_wren = 1'b1; cfg_ewsr = 1'b1;
         end else begin
            start = 1'b0;
         end
         if (done) begin
            done_cnt++;
            run_res = int'(result);
            start = 1'b0;
            break;
         end
         @(negedge clk);
      end
      start = 1'b0; cfg_wren = 1'b0; cfg_ewsr = 1'b0;
      // watch for a second done or a wide pulse
      for (int n = 0; n < 30; n++) begin
         @(negedge clk);
         if (done) done_cnt++;
      end
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk(spi_cs_n === 1'b1, "R1 cs_n", int'(spi_cs_n), 1);
      chk(spi_req === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 req/busy/done",
          int'({spi_req, busy, done}), 0);
      chk(result === 2'b00, "R1 result", int'(result), 0);
   endtask

   task automatic t_plain();
      run(8'hA5, 1'b1, 1'b0, 2, 8'h00, 0, 1'b0);
      chk(nfr == 5, "R2 frame count", nfr, 5);
      chk(fr_op[0] == 8'h06 && fr_len[0] == 1, "R2 enable frame", int'(fr_op[0]), 8'h06);
      chk(fr_op[1] == 8'h01 && fr_len[1] == 2, "R2 write frame shape", fr_len[1], 2);
      chk(fr_b1[1] == 8'hA5, "R2 written value", int'(fr_b1[1]), 8'hA5);
      chk(reads == 3 && fr_op[2] == 8'h05 && fr_len[2] == 2, "R8 busy polling reads", reads, 3);
      chk(init_delta >= INIT*CPM && init_delta <= INIT*CPM + 4, "R7 initial delay",
          init_delta, INIT*CPM);
      chk(step_min >= STEP*CPM && step_max <= STEP*CPM + 4, "R8 step delay", step_min, STEP*CPM);
      chk(min_gap >= GAP, "R12 chip-select gap", min_gap, GAP);
      chk(run_res == 0, "R8 result ok", run_res, 0);
      chk(done_cnt == 1, "R10 single done", done_cnt, 1);
      chk(busy_seen == 1'b1, "R10 busy during run", int'(busy_seen), 1);
      chk(result == 2'b00 && busy == 1'b0, "R10 result held", int'(result), 0);
   endtask

   task automatic t_no_flags();
      run(8'h3C, 1'b0, 1'b0, 0, 8'h00, 0, 1'b0);
      chk(fr_op[0] == 8'h50 && fr_len[0] == 1, "R3 default enable opcode", int'(fr_op[0]), 8'h50);
      chk(run_res == 0 && nfr == 3, "R3 completes", nfr, 3);
   endtask

   task automatic t_ewsr_only();
      run(8'h1C, 1'b0, 1'b1, 0, 8'h02, 0, 1'b0);
      chk(fr_op[0] == 8'h50 && fr_op[1] == 8'h01, "R4 status-enable style", int'(fr_op[0]), 8'h50);
      chk(reads == 1 && run_res == 0, "R8 latch bit ignored", reads, 1);
   endtask

   task automatic t_fallback();
      run(8'h5A, 1'b1, 1'b1, 0, 8'h00, 1, 1'b0);
      chk(nfr == 4 && fr_op[0] == 8'h06 && fr_op[1] == 8'h50, "R5 retry with 50h",
          int'(fr_op[1]), 8'h50);
      chk(fr_op[2] == 8'h01 && fr_b1[2] == 8'h5A, "R5 retry rewrites value", int'(fr_b1[2]), 8'h5A);
      chk(run_res == 0, "R5 retry result", run_res, 0);
   endtask

   task automatic t_no_fallback();
      run(8'h5A, 1'b1, 1'b0, 0, 8'h00, 1, 1'b0);
      chk(nfr == 1, "R5 no retry without flag", nfr, 1);
      chk(run_res == 1, "R6 enable error code", run_res, 1);
   endtask

   task automatic t_write_err();
      run(8'h77, 1'b0, 1'b1, 0, 8'h00, 2, 1'b0);
      chk(nfr == 2 && reads == 0, "R6 no polling after error", reads, 0);
      chk(run_res == 1, "R6 write error code", run_res, 1);
   endtask

   task automatic t_timeout();
      run(8'h04, 1'b0, 1'b1, 100000, 8'h00, 0, 1'b0);
      chk(reads == LIM + 1, "R9 read count at timeout", reads, LIM + 1);
      chk(run_res == 2, "R9 timeout code", run_res, 2);
      chk(done_cnt == 1, "R10 single done on timeout", done_cnt, 1);
   endtask

   task automatic t_start_ignored();
      run(8'h99, 1'b0, 1'b1, 1, 8'h00, 0, 1'b1);
      chk(nfr == 4 && fr_op[0] == 8'h50, "R11 opcode unchanged", int'(fr_op[0]), 8'h50);
      chk(fr_b1[1] == 8'h99, "R11 value unchanged", int'(fr_b1[1]), 8'h99);
      chk(done_cnt == 1, "R11 one done", done_cnt, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_plain();
      t_no_flags();
      t_ewsr_only();
      t_fallback();
      t_no_fallback();
      t_write_err();
      t_start_ignored();
      t_timeout();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule